// File: doc/BRIEF.md
# Seven-Input Ones Counter Built from Full Adders

This block takes a 7-bit vector and reports how many of its bits are set, as a 3-bit unsigned binary number. It is purely combinational. There is no clock and no reset, and the count follows the input directly.

It is built only from 1-bit full-adder cells, arranged as a carry-save reduction tree with the smallest possible cell count of four.

- **First level.** Two cells each compress three input bits.
- **Bit 0.** A third cell takes the seventh input bit together with the two first-level sums. Its sum is bit 0 of the count.
- **Bits 1 and 2.** A fourth cell adds the two first-level carries and the third cell's carry. Its sum is bit 1 of the count and its carry is bit 2.

The block suits places where a small population count must be formed with no adder beyond the 3:2 compressor. Examples are vote counting, weight checks, or the leaf of a larger compressor tree.

Top module: `popc7_top`

## Requirements
- R1: For every one of the 128 input values, `count_o` equals the number of set bits in `din_i`, as an unsigned binary number with bit 0 as the least significant bit.
- R2: An all-zero input gives a count of 3'b000.
- R3: An all-ones input gives a count of 3'b111.
- R4: Two inputs with the same number of set bits give the same count. For example, 7'b1100110 and 7'b1001110 both give 3'b100.
- R5: Bit 0 of `count_o` equals the XOR of all seven input bits.
- R6: Bit 2 of `count_o` is 1 exactly when four or more input bits are set.
- R7: An input with exactly one set bit gives 3'b001, whichever of the seven positions holds it.
- R8: The count is a function of the current input alone. Applying the same input again, after any other input, gives the same count, because no state is held.
- R9: The tree contains exactly four full-adder cells and no other arithmetic element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din_i | input | 7 | Vector whose set bits are counted |
| count_o | output | 3 | Number of set bits in `din_i`, unsigned binary |

## Verification
The bench sweeps all 128 inputs, so a miswired carry or sum path cannot hide. For example, routing a first-level carry into the bit-0 cell would break the parity of bit 0 on many patterns. Swapping the third cell's carry with its sum would corrupt counts of two and three.

The all-ones case (R3) and the boundary between three and four set bits (R6) are targeted on purpose. Dropping the final carry would report 7 as 3 and turn every count of four or more into a count below four.

Single-bit inputs at each position show that no input bit is lost or counted twice. The repeated-pattern pass after a reversed sweep would expose any hidden state left over from an earlier input.

// File: rtl/popc7_pkg.sv
package popc7_pkg;
   // Width of the vector being counted
   localparam int unsigned IN_W     = 7;
   // Width of the count, enough for 0..IN_W
   localparam int unsigned CNT_W    = $clog2(IN_W + 1);
   // Cells the minimal 3:2 tree needs for seven bits
   localparam int unsigned N_CELLS  = 4;

   // Internal form of one full-adder cell
   typedef enum logic [0:0] {
      FA_MAJORITY = 1'b0,   // carry as majority of three
      FA_PROPAGATE = 1'b1   // carry from generate/propagate pair
   } fa_style_e;

   // Output pair of a single full-adder cell
   typedef struct packed {
      logic carry;
      logic sum;
   } fa_out_t;
endpackage

// File: rtl/popc7_fa_cell.sv
module popc7_fa_cell
   import popc7_pkg::*;
#(
   parameter fa_style_e STYLE = FA_MAJORITY
) (
   input  logic    a_i,
   input  logic    b_i,
   input  logic    c_i,
   output fa_out_t res_o
);
   logic half_x;

   assign half_x = a_i ^ b_i;

   generate
      if (STYLE == FA_MAJORITY) begin : g_major
         assign res_o.sum   = half_x ^ c_i;
         assign res_o.carry = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
      end else begin : g_prop
         logic gen_x;
         assign gen_x       = a_i & b_i;
         assign res_o.sum   = half_x ^ c_i;
         assign res_o.carry = gen_x | (half_x & c_i);
      end
   endgenerate

   // R9: every cell adds its three inputs exactly
   always_comb begin
      cell_sum_chk : assert ({res_o.carry, res_o.sum} ==
                             2'(a_i) + 2'(b_i) + 2'(c_i))
         else $error("full-adder cell result wrong");
   end
endmodule

// File: rtl/popc7_csa_level.sv
module popc7_csa_level
   import popc7_pkg::*;
#(
   parameter int unsigned N_FA  = 2,
   parameter fa_style_e   STYLE = FA_MAJORITY
) (
   input  logic [3*N_FA-1:0] bits_i,
   output logic [N_FA-1:0]   sum_o,
   output logic [N_FA-1:0]   carry_o
);
   localparam int unsigned IN_BITS = 3 * N_FA;

   generate
      if (N_FA < 1) begin : g_bad_cnt
         $error("csa level needs at least one cell");
      end
      for (genvar k = 0; k < N_FA; k++) begin : g_cell
         fa_out_t r;
         popc7_fa_cell #(.STYLE(STYLE)) u_fa (
            .a_i  (bits_i[3*k]),
            .b_i  (bits_i[3*k+1]),
            .c_i  (bits_i[3*k+2]),
            .res_o(r)
         );
         assign sum_o[k]   = r.sum;
         assign carry_o[k] = r.carry;
      end
   endgenerate

   // R1: weight is preserved across the level (sums weigh 1, carries 2)
   always_comb begin
      level_weight_chk : assert (
         $countones(bits_i) ==
         $countones(sum_o) + 2 * $countones(carry_o))
         else $error("csa level lost weight over %0d bits", IN_BITS);
   end
endmodule

// File: rtl/popc7_top.sv
module popc7_top
   import popc7_pkg::*;
#(
   parameter fa_style_e FA_STYLE = FA_MAJORITY
) (
   input  logic [6:0] din_i,
   output logic [2:0] count_o
);
   localparam int unsigned L1_CELLS = (IN_W - 1) / 3;
   localparam int unsigned L2_CELLS = N_CELLS - L1_CELLS;

   generate
      if (IN_W != 7 || CNT_W != 3) begin : g_bad_w
         $error("tree is laid out for seven inputs and a 3-bit count");
      end
      // R9: two first-level cells plus two finishing cells
      if (L1_CELLS != 2 || L2_CELLS != 2) begin : g_bad_cells
         $error("tree must use exactly four cells");
      end
   endgenerate

   logic [L1_CELLS-1:0] l1_sum;
   logic [L1_CELLS-1:0] l1_carry;
   fa_out_t             low_r;
   fa_out_t             high_r;

   // First level: bits 0..5 in two groups of three
   popc7_csa_level #(.N_FA(L1_CELLS), .STYLE(FA_STYLE)) u_lvl1 (
      .bits_i (din_i[3*L1_CELLS-1:0]),
      .sum_o  (l1_sum),
      .carry_o(l1_carry)
   );

   // Weight-1 column: seventh bit and both first-level sums
   popc7_fa_cell #(.STYLE(FA_STYLE)) u_fa_low (
      .a_i  (din_i[IN_W-1]),
      .b_i  (l1_sum[0]),
      .c_i  (l1_sum[1]),
      .res_o(low_r)
   );

   // Weight-2 column: both first-level carries and the low carry
   popc7_fa_cell #(.STYLE(FA_STYLE)) u_fa_high (
      .a_i  (l1_carry[0]),
      .b_i  (l1_carry[1]),
      .c_i  (low_r.carry),
      .res_o(high_r)
   );

   assign count_o = {high_r.carry, high_r.sum, low_r.sum};

   always_comb begin
      // R5
      parity_bit_chk : assert (count_o[0] == ^din_i)
         else $error("count bit 0 is not input parity");
      // R6
      four_plus_chk : assert (count_o[2] == ($countones(din_i) >= 4))
         else $error("count bit 2 disagrees with four-or-more");
      // R2
      zero_in_chk : assert (din_i != '0 || count_o == 3'd0)
         else $error("zero input gave nonzero count");
      // R3
      all_ones_chk : assert (din_i != '1 || count_o == 3'd7)
         else $error("all-ones input did not give seven");
   end
endmodule

// File: tb/popc7_top_tb.sv
module popc7_top_tb;
   logic       clk = 1'b0;
   logic [6:0] din;
   logic [2:0] count;
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done  = 1'b0;

   always #5 clk = ~clk;

   popc7_top u_dut (
      .din_i  (din),
      .count_o(count)
   );

   function automatic int ref_count(input logic [6:0] v);
      int c = 0;
      for (int i = 0; i < 7; i++) if (v[i]) c++;
      return c;
   endfunction

   task automatic check(input string req, input logic [2:0] exp);
      n_cmp++;
      if (count !== exp) begin
         n_bad++;
         $display("FAIL %s din=%b actual=%0d expected=%0d", req, din, count, exp);
      end
   endtask

   // Apply on rising edge + 1, sample on falling edge
   task automatic apply(input logic [6:0] v);
      @(posedge clk);
      #1 din = v;
      @(negedge clk);
   endtask

   initial begin
      logic [2:0] first_res;
      din = '0;
      // R2
      apply(7'b0000000);
      check("R2", 3'd0);
      // R3
      apply(7'b1111111);
      check("R3", 3'd7);
      // R1 / R5 / R6: full sweep against behavioural count
      for (int v = 0; v < 128; v++) begin
         apply(7'(v));
         check("R1", 3'(ref_count(7'(v))));
         n_cmp++;
         if (count[0] !== ^7'(v)) begin
            n_bad++;
            $display("FAIL R5 din=%b actual=%b expected=%b", din, count[0], ^7'(v));
         end
         n_cmp++;
         if (count[2] !== (ref_count(7'(v)) >= 4)) begin
            n_bad++;
            $display("FAIL R6 din=%b actual=%b expected=%b", din, count[2],
                     ref_count(7'(v)) >= 4);
         end
      end
      // R4
      apply(7'b1100110);
      first_res = count;
      check("R4", 3'd4);
      apply(7'b1001110);
      check("R4", first_res);
      // R7: single set bit at each position
      for (int p = 0; p < 7; p++) begin
         apply(7'(1 << p));
         check("R7", 3'd1);
      end
      // R8: reversed sweep, no dependence on earlier inputs
      for (int v = 127; v >= 0; v--) begin
         apply(7'(v));
         check("R8", 3'(ref_count(7'(v))));
      end
      // R9: three-versus-four boundary exercises every cell carry
      apply(7'b0000111); check("R9", 3'd3);
      apply(7'b1000111); check("R9", 3'd4);
      apply(7'b0111000); check("R9", 3'd3);
      apply(7'b0111111); check("R9", 3'd6);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule